// File: doc/BRIEF.md
# Timed Serial Shift-Out Controller

This block moves one byte from a parallel input into a serial-in, parallel-out latch. It drives four lines: a select line, a serial data line, a shift clock and a latch strobe. A transfer starts when `start_i` is high while `ready_o` is high. The byte is then sent one bit at a time, and each bit passes through three timed phases. In the first, data is presented with the clock low. In the second, the clock is high. In the third, the clock is low again and data is held.

After the last bit, the block issues one latch strobe and waits a short tail. It then drops the select line and raises `done_o` for one cycle. Every phase length is a parameter counted in system-clock cycles. The select line and the three other lines can each be set active-low by parameter. After reset, every line sits at its inactive level.

Top module: `sso_top`

## Requirements
- R1: While reset is held, and after it is released with no start, each line is at its inactive level, `ready_o` is 1 and `done_o` is 0.
- R2: A transfer sends exactly DATA_W bits, most-significant bit first. Bit k of the sequence carries data bit DATA_W-1-k of the word captured at the start.
- R3: Each bit begins with SETUP_TICKS cycles in which the data line shows the bit and the shift clock is low, before the clock rises.
- R4: The shift clock is then high for exactly PULSE_TICKS cycles, and the data line does not change while it is high.
- R5: After the clock falls, the data line holds the same bit for HOLD_TICKS cycles with the clock low. Only then does the next bit's setup start.
- R6: The select line becomes active in the first setup cycle. It stays active through every bit, through the strobe and for HOLD_TICKS further cycles.
- R7: After the last bit's hold, the latch strobe is active for exactly PULSE_TICKS cycles, once per transfer. While it is active, the clock and data lines are at their inactive levels.
- R8: The data line is logically low whenever no bit phase is in progress.
- R9: With CS_ACTIVE_LOW=1 the select line is driven low when active. With LINE_ACTIVE_LOW=1 the data, clock and strobe lines are each driven inverted.
- R10: `ready_o` is low for the whole transfer. A start request (with any data) made while `ready_o` is low is ignored.
- R11: `done_o` is high for exactly one cycle: the first cycle in which the select line is inactive again.
- R12: From the edge that accepts a start to the cycle in which `done_o` is high, exactly DATA_W*(SETUP_TICKS+PULSE_TICKS+HOLD_TICKS)+PULSE_TICKS+HOLD_TICKS cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer request, taken when ready_o is high |
| data_i | input | DATA_W | Word to send, captured with the accepted start |
| ready_o | output | 1 | High when a new start will be accepted |
| done_o | output | 1 | One-cycle pulse after the select line is released |
| cs_o | output | 1 | Select line toward the latch (polarity by CS_ACTIVE_LOW) |
| sdo_o | output | 1 | Serial data line (polarity by LINE_ACTIVE_LOW) |
| sck_o | output | 1 | Shift clock, idles inactive (polarity by LINE_ACTIVE_LOW) |
| le_o | output | 1 | Latch strobe (polarity by LINE_ACTIVE_LOW) |

## Verification
The assertions look at the logical line levels, before the polarity stage. Several of them assume that SETUP_TICKS, PULSE_TICKS and HOLD_TICKS are each at least one. Without that, a clock edge could coincide with a data change, or two done pulses could touch. The stimulus holds these parameters at their defaults. It also changes `start_i` and `data_i` only away from the active edge, so every accepted start sees a settled word.

The bench includes deliberate start requests, with different data, in the middle of transfers. It also includes back-to-back starts raised in the done cycle. Together these cover both sides of the ready boundary.

// File: rtl/sso_pkg.sv
package sso_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_LATCH = 3'd4,
    PH_GAP   = 3'd5
  } phase_e;

  // Logical (active-high) line levels before the polarity stage.
  typedef struct packed {
    logic sel;
    logic dat;
    logic sck;
    logic stb;
  } lines_t;

  // Cycles spent in a given phase.
  function automatic int unsigned phase_ticks(phase_e ph, int unsigned s,
                                              int unsigned p, int unsigned h);
    int unsigned n;
    case (ph)
      PH_SETUP: n = s;
      PH_PULSE: n = p;
      PH_HOLD:  n = h;
      PH_LATCH: n = p;
      PH_GAP:   n = h;
      default:  n = 1;
    endcase
    return n;
  endfunction

  // Cycles from accepted start to the done cycle.
  function automatic int unsigned frame_cycles(int unsigned w, int unsigned s,
                                               int unsigned p, int unsigned h);
    return w * (s + p + h) + p + h;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b,
                                       int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic is_bit_phase(phase_e ph);
    return (ph == PH_SETUP) || (ph == PH_PULSE) || (ph == PH_HOLD);
  endfunction

endpackage

// File: rtl/sso_phase_timer.sv
module sso_phase_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sso_shift_reg.sv
module sso_shift_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_load,
  input  logic [W-1:0] word_in,
  input  logic         shift_adv,
  output logic         msb_d,
  output logic         bit_last
);

  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (word_load) begin
      sh_q  <= word_in;
      idx_q <= '0;
    end else if (shift_adv) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  // Bit that will be on the data line after the coming edge.
  always_comb begin
    if (word_load)      msb_d = word_in[W-1];
    else if (shift_adv) msb_d = sh_q[W-2];
    else                msb_d = sh_q[W-1];
  end

  assign bit_last = (idx_q == IW'(W - 1));

endmodule

// File: rtl/sso_sequencer.sv
module sso_sequencer
  import sso_pkg::*;
#(
  parameter int unsigned SETUP_TICKS = 1,
  parameter int unsigned PULSE_TICKS = 2,
  parameter int unsigned HOLD_TICKS  = 3,
  parameter int unsigned CW          = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick_last,
  input  logic          bit_last,
  output phase_e        phase_q,
  output phase_e        phase_d,
  output logic          tick_load,
  output logic [CW-1:0] tick_val,
  output logic          shift_adv,
  output logic          word_load,
  output logic          frame_end
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_comb begin
    phase_d   = phase_q;
    tick_load = 1'b0;
    shift_adv = 1'b0;
    word_load = 1'b0;
    frame_end = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d   = PH_SETUP;
          tick_load = 1'b1;
          word_load = 1'b1;
        end
      end
      PH_SETUP: begin
        if (tick_last) begin
          phase_d   = PH_PULSE;
          tick_load = 1'b1;
        end
      end
      PH_PULSE: begin
        if (tick_last) begin
          phase_d   = PH_HOLD;
          tick_load = 1'b1;
        end
      end
      PH_HOLD: begin
        if (tick_last) begin
          tick_load = 1'b1;
          if (bit_last) begin
            phase_d = PH_LATCH;
          end else begin
            phase_d   = PH_SETUP;
            shift_adv = 1'b1;
          end
        end
      end
      PH_LATCH: begin
        if (tick_last) begin
          phase_d   = PH_GAP;
          tick_load = 1'b1;
        end
      end
      PH_GAP: begin
        if (tick_last) begin
          phase_d   = PH_IDLE;
          frame_end = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign tick_val = CW'(phase_ticks(phase_d, SETUP_TICKS, PULSE_TICKS, HOLD_TICKS) - 1);

endmodule

// File: rtl/sso_line_drive.sv
module sso_line_drive
  import sso_pkg::*;
#(
  parameter bit CS_INV   = 1'b1,
  parameter bit LINE_INV = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_d,
  input  logic   msb_d,
  input  logic   frame_end,
  output lines_t log_q,
  output logic   done_q,
  output logic   cs_o,
  output logic   sdo_o,
  output logic   sck_o,
  output logic   le_o
);

  lines_t log_d;

  always_comb begin
    log_d.sel = (phase_d != PH_IDLE);
    log_d.dat = is_bit_phase(phase_d) & msb_d;
    log_d.sck = (phase_d == PH_PULSE);
    log_d.stb = (phase_d == PH_LATCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_q  <= '0;
      done_q <= 1'b0;
    end else begin
      log_q  <= log_d;
      done_q <= frame_end;
    end
  end

  assign cs_o  = log_q.sel ^ CS_INV;
  assign sdo_o = log_q.dat ^ LINE_INV;
  assign sck_o = log_q.sck ^ LINE_INV;
  assign le_o  = log_q.stb ^ LINE_INV;

endmodule

// File: rtl/sso_top.sv
module sso_top
  import sso_pkg::*;
#(
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned SETUP_TICKS     = 1,
  parameter int unsigned PULSE_TICKS     = 2,
  parameter int unsigned HOLD_TICKS      = 3,
  parameter bit          CS_ACTIVE_LOW   = 1'b1,
  parameter bit          LINE_ACTIVE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              cs_o,
  output logic              sdo_o,
  output logic              sck_o,
  output logic              le_o
);

  localparam int unsigned TICK_MAX = max3(SETUP_TICKS, PULSE_TICKS, HOLD_TICKS);
  localparam int unsigned CW       = $clog2(TICK_MAX + 1);

  phase_e        phase_q, phase_d;
  logic          tick_load, tick_last;
  logic [CW-1:0] tick_val;
  logic          bit_adv, word_load, bit_last, msb_d;
  logic          frame_end;
  lines_t        lines_l;

  // Named logical levels, brought out for the checker.
  logic sel_l, dat_l, sck_l, stb_l;

  sso_sequencer #(
    .SETUP_TICKS(SETUP_TICKS),
    .PULSE_TICKS(PULSE_TICKS),
    .HOLD_TICKS (HOLD_TICKS),
    .CW         (CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .tick_last(tick_last),
    .bit_last (bit_last),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .tick_load(tick_load),
    .tick_val (tick_val),
    .shift_adv(bit_adv),
    .word_load(word_load),
    .frame_end(frame_end)
  );

  sso_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tick_load),
    .load_val(tick_val),
    .last    (tick_last)
  );

  sso_shift_reg #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_load(word_load),
    .word_in  (data_i),
    .shift_adv(bit_adv),
    .msb_d    (msb_d),
    .bit_last (bit_last)
  );

  sso_line_drive #(
    .CS_INV  (CS_ACTIVE_LOW),
    .LINE_INV(LINE_ACTIVE_LOW)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_d  (phase_d),
    .msb_d    (msb_d),
    .frame_end(frame_end),
    .log_q    (lines_l),
    .done_q   (done_o),
    .cs_o     (cs_o),
    .sdo_o    (sdo_o),
    .sck_o    (sck_o),
    .le_o     (le_o)
  );

  assign ready_o = (phase_q == PH_IDLE);
  assign sel_l   = lines_l.sel;
  assign dat_l   = lines_l.dat;
  assign sck_l   = lines_l.sck;
  assign stb_l   = lines_l.stb;

endmodule

// File: rtl/sso_top_checks.sv
module sso_top_checks #(
  parameter int unsigned DATA_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic ready_o,
  input logic done_o,
  input logic sel_l,
  input logic dat_l,
  input logic sck_l,
  input logic stb_l
);

  localparam int unsigned NW = $clog2(DATA_W + 2);

  logic [NW-1:0] rises_q;
  logic          sck_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises_q    <= '0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_l;
      if (!sel_l)                   rises_q <= '0;
      else if (sck_l && !sck_prev_q) rises_q <= rises_q + 1'b1;
    end
  end

  assert_eight_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_l) |-> (rises_q == NW'(DATA_W)));

  assert_setup_before_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_l) |-> ($past(sel_l) && $stable(dat_l)));

  assert_data_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_l && $past(sck_l)) |-> $stable(dat_l));

  assert_data_held_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_l) |-> $stable(dat_l));

  assert_clock_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sck_l |-> sel_l);

  assert_strobe_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_l |-> sel_l);

  assert_strobe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_l |-> (!sck_l && !dat_l));

  assert_idle_data_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_l |-> !dat_l);

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_l |-> !ready_o);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!sel_l && $past(sel_l) && ready_o));

endmodule

bind sso_top sso_top_checks #(.DATA_W(DATA_W)) u_checks (
  .clk    (clk),
  .rst_n  (rst_n),
  .ready_o(ready_o),
  .done_o (done_o),
  .sel_l  (sel_l),
  .dat_l  (dat_l),
  .sck_l  (sck_l),
  .stb_l  (stb_l)
);

// File: tb/sso_top_test.sv
module sso_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 8;
  localparam int TS    = 1;
  localparam int TP    = 2;
  localparam int TH    = 3;
  localparam int FRAME = W * (TS + TP + TH) + TP + TH;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] din = '0;

  logic rdy_a, done_a, cs_a, sdo_a, sck_a, le_a;
  logic rdy_b, done_b, cs_b, sdo_b, sck_b, le_b;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int acc_cyc = 0;
  bit finished = 1'b0;

  // Expected logical word per cycle: {sel, dat, sck, stb}.
  logic [3:0] q[$];
  bit done_exp = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Active-low select, true lines.
  sso_top #(.DATA_W(W), .SETUP_TICKS(TS), .PULSE_TICKS(TP), .HOLD_TICKS(TH),
            .CS_ACTIVE_LOW(1'b1), .LINE_ACTIVE_LOW(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .data_i(din),
    .ready_o(rdy_a), .done_o(done_a), .cs_o(cs_a), .sdo_o(sdo_a),
    .sck_o(sck_a), .le_o(le_a));

  // Active-high select, inverted lines (R9).
  sso_top #(.DATA_W(W), .SETUP_TICKS(TS), .PULSE_TICKS(TP), .HOLD_TICKS(TH),
            .CS_ACTIVE_LOW(1'b0), .LINE_ACTIVE_LOW(1'b1)) uut_inv (
    .clk(clk), .rst_n(rst_n), .start_i(start), .data_i(din),
    .ready_o(rdy_b), .done_o(done_b), .cs_o(cs_b), .sdo_o(sdo_b),
    .sck_o(sck_b), .le_o(le_b));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic push_frame(logic [W-1:0] b);
    for (int k = W - 1; k >= 0; k--) begin
      for (int i = 0; i < TS; i++) q.push_back({1'b1, b[k], 1'b0, 1'b0});
      for (int i = 0; i < TP; i++) q.push_back({1'b1, b[k], 1'b1, 1'b0});
      for (int i = 0; i < TH; i++) q.push_back({1'b1, b[k], 1'b0, 1'b0});
    end
    for (int i = 0; i < TP; i++) q.push_back(4'b1001);
    for (int i = 0; i < TH; i++) q.push_back(4'b1000);
  endtask

  task automatic model_step();
    cyc++;
    if (q.size() != 0) begin
      void'(q.pop_front());
      done_exp = (q.size() == 0);
    end else begin
      done_exp = 1'b0;
      if (start) begin
        push_frame(din);
        acc_cyc = cyc;
      end
    end
  endtask

  task automatic compare();
    logic [3:0] e;
    logic       idle;
    idle = (q.size() == 0);
    e = idle ? 4'b0000 : q[0];
    chk("R6 select line",          cs_a,   ~e[3]);
    chk("R2 R3 R5 R8 data line",   sdo_a,  e[2]);
    chk("R4 shift clock",          sck_a,  e[1]);
    chk("R7 latch strobe",         le_a,   e[0]);
    chk("R10 ready",               rdy_a,  idle);
    chk("R11 done",                done_a, done_exp);
    chk("R9 inverted select",      cs_b,   e[3]);
    chk("R9 inverted data",        sdo_b,  ~e[2]);
    chk("R9 inverted clock",       sck_b,  ~e[1]);
    chk("R9 inverted strobe",      le_b,   ~e[0]);
    chk("R9 ready",                rdy_b,  idle);
    chk("R9 done",                 done_b, done_exp);
    if (done_a === 1'b1) begin
      checks++;
      if (cyc - acc_cyc != FRAME) begin
        errors++;
        $display("FAIL R12 frame length actual=%0d expected=%0d", cyc - acc_cyc, FRAME);
      end
    end
  endtask

  task automatic cycle(logic s, logic [W-1:0] d);
    start = s;
    din   = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, '0);
  endtask

  // Accepts a word, then runs the frame; optional mid-frame start requests (R10).
  task automatic send(logic [W-1:0] b, bit poke);
    cycle(1'b1, b);
    for (int i = 0; i < FRAME; i++) cycle(poke ? logic'(i % 7 == 3) : 1'b0, ~b);
  endtask

  initial begin
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    // R1: reset levels
    chk("R1 reset select",  cs_a,   1'b1);
    chk("R1 reset data",    sdo_a,  1'b0);
    chk("R1 reset clock",   sck_a,  1'b0);
    chk("R1 reset strobe",  le_a,   1'b0);
    chk("R1 reset ready",   rdy_a,  1'b1);
    chk("R1 reset done",    done_a, 1'b0);
    chk("R1 R9 reset inverted select", cs_b,  1'b0);
    chk("R1 R9 reset inverted data",   sdo_b, 1'b1);
    chk("R1 R9 reset inverted clock",  sck_b, 1'b1);
    chk("R1 R9 reset inverted strobe", le_b,  1'b1);
    rst_n = 1'b1;
    idle_cycles(3);                 // R1 after release
    send(8'hA5, 1'b0);
    idle_cycles(2);
    send(8'h00, 1'b1);              // R10 ignored requests
    send(8'hFF, 1'b1);              // back to back, start in done cycle
    idle_cycles(1);
    send(8'h81, 1'b0);
    send(8'h3C, 1'b1);
    idle_cycles(4);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule